// File: doc/BRIEF.md
# Reservation Station Bank with Result Snooping

This block is a small pool of waiting slots placed in front of a single floating-point execution unit. An upstream issue stage hands it one operation at a time, with an opcode and two sources. Each source is either a finished value or the tag of the slot that will produce that value. The bank puts the operation into its lowest-numbered empty slot and returns that slot's tag, so the rename logic can record which slot will produce the result.

Slots whose sources are still pending watch a shared result bus that carries a tag and a value. A slot copies the value into each source whose tag matches the one on the bus. A slot with both sources present is offered to the execution unit over a valid/ready handshake. The lowest-numbered such slot is offered, and the offer is held until the unit takes it. A slot that has been handed over stays occupied until its own tag appears on the result bus, and then it becomes free again. Younger operations whose sources are ready can therefore run ahead of older ones that are still waiting.

Top module: `rsb_bank`

## Requirements
- R1: After reset every slot is empty: `iss_ready_o` is 1, `iss_tag_o` is 1 and `dsp_valid_o` is 0.
- R2: An accepted issue fills the lowest-numbered empty slot, and `iss_tag_o` gives that slot's tag beforehand (slots are tagged 1 to N). When all slots are occupied, `iss_ready_o` is 0 and an issue request writes nothing.
- R3: A source tag of 0 means the accompanying value is used as is, and that source counts as present at once.
- R4: A source with a nonzero tag waits. It takes `bc_val_i` in the cycle that `bc_valid_i` is high and `bc_tag_i` equals its tag. A broadcast with any other tag leaves it unchanged. A captured value is kept until the slot is reused.
- R5: If a broadcast in the same cycle as the issue matches an incoming source tag, that source is filled with the broadcast value during the issue itself.
- R6: A slot is offered only while it is occupied, both of its sources are present and it has not yet been handed over. The offer carries that slot's opcode, both source values and its tag.
- R7: When several slots are eligible, the lowest-numbered one is offered. At most one slot is handed over per cycle. An offer that is not accepted stays unchanged until `dsp_ready_i` is high.
- R8: A slot that has been handed over stays occupied until a broadcast carries its own tag, and then it is free. A broadcast of the tag of a slot that has not been handed over does not free that slot.
- R9: A younger slot whose sources are present is offered ahead of an older slot that is still waiting.
- R10: A broadcast with tag 0 fills no source and frees no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iss_valid_i | input | 1 | Issue request |
| iss_ready_o | output | 1 | At least one slot is empty |
| iss_tag_o | output | TAG_W | Tag the next accepted issue will receive |
| iss_op_i | input | OP_W | Opcode of the issued operation |
| iss_a_tag_i | input | TAG_W | Producer tag of source A, 0 if value present |
| iss_a_val_i | input | DATA_W | Value of source A |
| iss_b_tag_i | input | TAG_W | Producer tag of source B, 0 if value present |
| iss_b_val_i | input | DATA_W | Value of source B |
| bc_valid_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | TAG_W | Tag of the broadcast result |
| bc_val_i | input | DATA_W | Broadcast result value |
| dsp_valid_o | output | 1 | A slot is offered to the execution unit |
| dsp_ready_i | input | 1 | Execution unit accepts the offer |
| dsp_op_o | output | OP_W | Opcode of the offered slot |
| dsp_a_o | output | DATA_W | Source A value of the offered slot |
| dsp_b_o | output | DATA_W | Source B value of the offered slot |
| dsp_tag_o | output | TAG_W | Tag of the offered slot |

## Verification
The assertions check the following on every cycle:
- a source that holds a value keeps it until the slot is reused, and a match at issue time fills the source;
- a slot is handed over only while it is eligible, and at most one slot is handed over per cycle;
- a stalled offer does not change;
- a full bank does not gain an occupant;
- a slot is freed only by a broadcast of its own tag after it has been handed over.

Only the bench scenarios can show the following:
- the actual values that reach the execution unit;
- the lowest-first choice among both empty and eligible slots;
- a younger slot overtaking an older one that is waiting;
- broadcasts that match nothing, including tag 0, leaving the bank unchanged.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int unsigned RSB_ENTRIES = 4;
  localparam int unsigned RSB_DATA_W  = 32;
  localparam int unsigned RSB_OP_W    = 4;
endpackage

// File: rtl/rsb_lowest.sv
module rsb_lowest #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/rsb_operand.sv
module rsb_operand #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TAG_W-1:0]  src_tag_i,
  input  logic [DATA_W-1:0] src_val_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_val_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] val_o
);
  logic              rdy_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;
  logic              hit_new, hit_wait;

  assign hit_new  = bc_valid_i && (bc_tag_i == src_tag_i);
  assign hit_wait = bc_valid_i && !rdy_q && (bc_tag_i == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      tag_q <= '0;
      val_q <= '0;
    end else if (load_i) begin
      tag_q <= src_tag_i;
      if (src_tag_i == '0) begin
        rdy_q <= 1'b1;
        val_q <= src_val_i;
      end else if (hit_new) begin
        // same-cycle wakeup
        rdy_q <= 1'b1;
        val_q <= bc_val_i;
      end else begin
        rdy_q <= 1'b0;
      end
    end else if (hit_wait) begin
      rdy_q <= 1'b1;
      val_q <= bc_val_i;
    end
  end

  assign rdy_o = rdy_q;
  assign val_o = val_q;

  // R4
  value_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q && !load_i |=> rdy_q && $stable(val_q));

  // R5
  issue_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (src_tag_i != '0) && bc_valid_i && (bc_tag_i == src_tag_i)
      |=> rdy_q && (val_q == $past(bc_val_i)));
endmodule

// File: rtl/rsb_entry.sv
module rsb_entry #(
  parameter int unsigned OP_W   = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 3,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic [DATA_W-1:0] a_val_i,
  input  logic [TAG_W-1:0]  b_tag_i,
  input  logic [DATA_W-1:0] b_val_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_val_i,
  input  logic              take_i,
  output logic              busy_o,
  output logic              rdy_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  logic busy_q, sent_q, own_hit, a_rdy, b_rdy;
  logic [OP_W-1:0] op_q;

  assign own_hit = bc_valid_i && (bc_tag_i == MY_TAG) && sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      op_q   <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      sent_q <= 1'b0;
      op_q   <= op_i;
    end else if (own_hit) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
    end else if (take_i) begin
      sent_q <= 1'b1;
    end
  end

  rsb_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_a (
    .clk_i, .rst_ni, .load_i(alloc_i), .src_tag_i(a_tag_i), .src_val_i(a_val_i),
    .bc_valid_i, .bc_tag_i, .bc_val_i, .rdy_o(a_rdy), .val_o(a_o)
  );
  rsb_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_b (
    .clk_i, .rst_ni, .load_i(alloc_i), .src_tag_i(b_tag_i), .src_val_i(b_val_i),
    .bc_valid_i, .bc_tag_i, .bc_val_i, .rdy_o(b_rdy), .val_o(b_o)
  );

  assign busy_o = busy_q;
  assign rdy_o  = busy_q && !sent_q && a_rdy && b_rdy;
  assign op_o   = op_q;

  // R6
  take_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> busy_q && !sent_q && a_rdy && b_rdy);

  // R8
  free_on_own_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(bc_valid_i && (bc_tag_i == MY_TAG) && sent_q));
endmodule

// File: rtl/rsb_bank.sv
module rsb_bank #(
  parameter int unsigned N_ENT  = rsb_pkg::RSB_ENTRIES,
  parameter int unsigned DATA_W = rsb_pkg::RSB_DATA_W,
  parameter int unsigned OP_W   = rsb_pkg::RSB_OP_W,
  parameter int unsigned TAG_W  = $clog2(N_ENT + 1),
  parameter int unsigned IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  output logic              iss_ready_o,
  output logic [TAG_W-1:0]  iss_tag_o,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [TAG_W-1:0]  iss_a_tag_i,
  input  logic [DATA_W-1:0] iss_a_val_i,
  input  logic [TAG_W-1:0]  iss_b_tag_i,
  input  logic [DATA_W-1:0] iss_b_val_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_val_i,
  output logic              dsp_valid_o,
  input  logic              dsp_ready_i,
  output logic [OP_W-1:0]   dsp_op_o,
  output logic [DATA_W-1:0] dsp_a_o,
  output logic [DATA_W-1:0] dsp_b_o,
  output logic [TAG_W-1:0]  dsp_tag_o
);
  logic [N_ENT-1:0]  busy, rdy, free_gnt, rdy_gnt, alloc, take;
  logic              free_any, rdy_any, fire, lock_q;
  logic [IDX_W-1:0]  free_idx, rdy_idx, sel_idx, lock_idx_q;
  logic [OP_W-1:0]   ent_op [N_ENT];
  logic [DATA_W-1:0] ent_a  [N_ENT];
  logic [DATA_W-1:0] ent_b  [N_ENT];

  rsb_lowest #(.N(N_ENT), .IDX_W(IDX_W)) u_free (
    .req_i(~busy), .gnt_o(free_gnt), .any_o(free_any), .idx_o(free_idx)
  );
  rsb_lowest #(.N(N_ENT), .IDX_W(IDX_W)) u_pick (
    .req_i(rdy), .gnt_o(rdy_gnt), .any_o(rdy_any), .idx_o(rdy_idx)
  );

  assign iss_ready_o = free_any;
  assign iss_tag_o   = TAG_W'(free_idx) + TAG_W'(1);
  assign alloc       = (iss_valid_i && free_any) ? free_gnt : '0;

  // stalled offer is pinned so the handshake stays stable
  assign sel_idx     = lock_q ? lock_idx_q : rdy_idx;
  assign dsp_valid_o = lock_q || rdy_any;
  assign fire        = dsp_valid_o && dsp_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= dsp_valid_o && !dsp_ready_i;
      lock_idx_q <= sel_idx;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign take[g] = fire && (sel_idx == IDX_W'(g));
    rsb_entry #(
      .OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .MY_TAG(TAG_W'(g + 1))
    ) u_ent (
      .clk_i, .rst_ni,
      .alloc_i(alloc[g]), .op_i(iss_op_i),
      .a_tag_i(iss_a_tag_i), .a_val_i(iss_a_val_i),
      .b_tag_i(iss_b_tag_i), .b_val_i(iss_b_val_i),
      .bc_valid_i, .bc_tag_i, .bc_val_i,
      .take_i(take[g]), .busy_o(busy[g]), .rdy_o(rdy[g]),
      .op_o(ent_op[g]), .a_o(ent_a[g]), .b_o(ent_b[g])
    );
  end

  assign dsp_op_o  = ent_op[sel_idx];
  assign dsp_a_o   = ent_a[sel_idx];
  assign dsp_b_o   = ent_b[sel_idx];
  assign dsp_tag_o = TAG_W'(sel_idx) + TAG_W'(1);

  // R7
  one_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take));

  // R7
  offer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_valid_o && !dsp_ready_i |=> dsp_valid_o && $stable(dsp_tag_o)
      && $stable(dsp_a_o) && $stable(dsp_b_o) && $stable(dsp_op_o));

  // R2
  full_no_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_i && !iss_ready_o |=> $countones(busy) <= $past($countones(busy)));
endmodule

// File: tb/sim_rsb_bank.sv
module sim_rsb_bank;
  localparam int unsigned TAG_W = 3;
  localparam int unsigned NROW  = 8;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        iss_valid_i = 1'b0, iss_ready_o;
  logic [2:0]  iss_tag_o, iss_a_tag_i = '0, iss_b_tag_i = '0;
  logic [3:0]  iss_op_i = '0, dsp_op_o;
  logic [31:0] iss_a_val_i = '0, iss_b_val_i = '0, bc_val_i = '0;
  logic        bc_valid_i = 1'b0, dsp_valid_o, dsp_ready_i = 1'b0;
  logic [2:0]  bc_tag_i = '0, dsp_tag_o;
  logic [31:0] dsp_a_o, dsp_b_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  rsb_bank u0 (.*);

  // row: op, a_tag, a_val, b_tag, b_val
  localparam logic [73:0] VEC [NROW] = '{
    {4'h1, 3'd0, 32'h1111_1111, 3'd0, 32'h2222_2222},
    {4'h2, 3'd5, 32'h0000_0000, 3'd0, 32'h0000_0033},
    {4'h3, 3'd0, 32'h0000_0044, 3'd6, 32'h0000_0000},
    {4'h4, 3'd5, 32'h0000_0000, 3'd6, 32'h0000_0000},
    {4'h5, 3'd7, 32'h0000_0000, 3'd7, 32'h0000_0000},
    {4'h6, 3'd6, 32'h0000_0000, 3'd5, 32'h0000_0000},
    {4'hF, 3'd0, 32'hFFFF_FFFF, 3'd0, 32'h0000_0000},
    {4'h0, 3'd7, 32'h0000_0000, 3'd0, 32'h8000_0000}
  };

  function automatic logic [31:0] bcv(input logic [2:0] t);
    return 32'hC0DE_0000 | 32'(t);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic issue(input logic [3:0] op, input logic [2:0] at, input logic [31:0] av,
                       input logic [2:0] bt, input logic [31:0] bv);
    iss_op_i = op; iss_a_tag_i = at; iss_a_val_i = av;
    iss_b_tag_i = bt; iss_b_val_i = bv; iss_valid_i = 1'b1;
    tick();
    iss_valid_i = 1'b0;
  endtask

  task automatic bcast(input logic [2:0] t, input logic [31:0] v);
    bc_tag_i = t; bc_val_i = v; bc_valid_i = 1'b1;
    tick();
    bc_valid_i = 1'b0;
  endtask

  task automatic accept();
    dsp_ready_i = 1'b1;
    tick();
    dsp_ready_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick();
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check("R1 ready", 32'(iss_ready_o), 32'd1);
    check("R1 tag", 32'(iss_tag_o), 32'd1);
    check("R1 dsp_valid", 32'(dsp_valid_o), 32'd0);

    for (int r = 0; r < NROW; r++) begin
      logic [3:0]  op; logic [2:0] at, bt; logic [31:0] av, bv;
      {op, at, av, bt, bv} = VEC[r];
      do_reset();
      check("R2 tag before issue", 32'(iss_tag_o), 32'd1);
      issue(op, at, av, bt, bv);
      // R3 both ready at issue / R6 waiting otherwise
      check("R3/R6 valid after issue", 32'(dsp_valid_o), 32'((at == 0) && (bt == 0)));
      bcast(3'd0, 32'hDEAD_0000);   // R10
      bcast(3'd4, 32'hBEEF_0000);   // R4 non-matching
      check("R10/R4 valid after decoys", 32'(dsp_valid_o), 32'((at == 0) && (bt == 0)));
      if (at != 0) begin
        bcast(at, bcv(at));
        if (bt != 0 && bt != at)
          check("R6 still waiting on b", 32'(dsp_valid_o), 32'd0);
      end
      if (bt != 0 && bt != at) bcast(bt, bcv(bt));
      check("R6 valid", 32'(dsp_valid_o), 32'd1);
      check("R6 op", 32'(dsp_op_o), 32'(op));
      check("R4 a", dsp_a_o, (at == 0) ? av : bcv(at));
      check("R4 b", dsp_b_o, (bt == 0) ? bv : bcv(bt));
      check("R6 tag", 32'(dsp_tag_o), 32'd1);
      accept();
      check("R6 no re-offer", 32'(dsp_valid_o), 32'd0);
      check("R8 still busy", 32'(iss_tag_o), 32'd2);
      bcast(3'd1, 32'h0);
      check("R8 freed", 32'(iss_tag_o), 32'd1);
    end

    // R2 / R7 / R8 / R9 directed
    do_reset();
    issue(4'h1, 3'd5, 32'h0, 3'd0, 32'h10);
    check("R2 tag 2", 32'(iss_tag_o), 32'd2);
    issue(4'h2, 3'd5, 32'h0, 3'd0, 32'h20);
    check("R2 tag 3", 32'(iss_tag_o), 32'd3);
    issue(4'h3, 3'd6, 32'h0, 3'd0, 32'h30);
    check("R2 tag 4", 32'(iss_tag_o), 32'd4);
    issue(4'h4, 3'd0, 32'h40, 3'd0, 32'h41);
    check("R2 full", 32'(iss_ready_o), 32'd0);
    check("R9 younger first", 32'(dsp_tag_o), 32'd4);
    check("R9 valid", 32'(dsp_valid_o), 32'd1);
    issue(4'h9, 3'd0, 32'h99, 3'd0, 32'h98);
    check("R2 full ignored", 32'(iss_ready_o), 32'd0);
    bcast(3'd5, 32'h55);
    check("R7 hold tag", 32'(dsp_tag_o), 32'd4);
    check("R7 hold a", dsp_a_o, 32'h40);
    accept();
    check("R7 lowest", 32'(dsp_tag_o), 32'd1);
    check("R2/R4 slot1 a", dsp_a_o, 32'h55);
    check("R2 slot1 op", 32'(dsp_op_o), 32'h1);
    accept();
    check("R7 next", 32'(dsp_tag_o), 32'd2);
    check("R4 slot2 b", dsp_b_o, 32'h20);
    accept();
    check("R6 none eligible", 32'(dsp_valid_o), 32'd0);
    check("R8 dispatched stay busy", 32'(iss_ready_o), 32'd0);
    bcast(3'd3, 32'h33);
    check("R8 undispatched not freed", 32'(iss_ready_o), 32'd0);
    bcast(3'd2, 32'h222);
    check("R8 free after own tag", 32'(iss_ready_o), 32'd1);
    check("R8 freed slot", 32'(iss_tag_o), 32'd2);
    bcast(3'd6, 32'h66);
    check("R8 slot3 kept", 32'(dsp_tag_o), 32'd3);
    check("R4 slot3 a", dsp_a_o, 32'h66);
    check("R4 slot3 b", dsp_b_o, 32'h30);

    // R5 same-cycle capture
    do_reset();
    bc_tag_i = 3'd7; bc_val_i = 32'h77; bc_valid_i = 1'b1;
    issue(4'h5, 3'd7, 32'h0, 3'd0, 32'h5);
    bc_valid_i = 1'b0;
    check("R5 valid", 32'(dsp_valid_o), 32'd1);
    check("R5 a", dsp_a_o, 32'h77);

    finish_run();
  end
endmodule